// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches a vector of 54 input pins and records, per pin, whether an event of interest has happened. Six kinds of detector can be armed independently for every pin. Four of them work on a synchronised copy of the pin: rising edge, falling edge, high level and low level. Two work on the raw pin: a fast rising edge and a fast falling edge that skip the synchroniser delay. Any armed detector that fires sets a sticky pending bit for that pin. Software clears the bit by writing a one to it.

The pending bits are folded into three interrupt lines. Each line covers a fixed, contiguous span of pins, and the middle span crosses the boundary between the two 32-bit register words. Software reaches the block through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the presented address. Pin multiplexing and output driving belong to other blocks.

Top module: `gpev_top`

## Requirements
- R1: After reset, every arm register and both pending words read 0 and all three interrupt lines are low.
- R2: Register words sit at byte addresses 0x40/0x44 (pending, pins 0-31 / 32-53), then arm registers at 0x4C (sync rising), 0x58 (sync falling), 0x64 (high level), 0x70 (low level), 0x7C (fast rising) and 0x88 (fast falling), each with its upper word at +4. Arm registers read back what was written, and bits 31:22 of every upper word read 0.
- R3: With sync rising armed, a pin that goes high between two clock edges shows its pending bit after the third rising clock edge, and not after the second.
- R4: Sync falling arming detects a high-to-low change with the same latency. A pin with both sync edges armed is flagged on each direction.
- R5: A level detector sets the pending bit on every cycle its condition holds, so a clear written while the condition holds leaves the bit at 1.
- R6: Fast rising/falling arming flags the pin after the first rising clock edge that follows the change.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: When a new event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Disarming a pin's detectors does not clear its pending bit.
- R10: Interrupt line 0 is high while any pending bit of pins 0-27 is set, line 1 for pins 28-45, line 2 for pins 46-53. Each line follows the pending bits in the same cycle.
- R11: Pin activity with no detector armed sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 54 | Pin levels, asynchronous to the clock |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for the presented address |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
Random rounds hold the pins at one random pattern, arm a random mix of all six detectors, and then move the pins to a second random pattern. Pins that stayed put exercise only the level detectors, and pins that moved exercise edge and level together, so the expected pending vector separates each detector kind from the others. Directed cases pin down the edge on which the sync and fast paths latch, set-over-clear priority, level re-assertion against a clear, and the pins at the edges of the interrupt spans (27/28, 45/46). The 45/46 pair sits in the upper word, away from the word boundary.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    localparam int NUM_KIND = 6;
    localparam int NUM_IRQ  = 3;

    // Detector kinds; the order sets the register layout.
    typedef enum logic [2:0] {
        K_SRISE = 3'd0,
        K_SFALL = 3'd1,
        K_HIGH  = 3'd2,
        K_LOW   = 3'd3,
        K_ARISE = 3'd4,
        K_AFALL = 3'd5
    } det_kind_e;

    // Pending words first, then one group of words per kind.
    localparam int PEND_BASE    = 'h40;
    localparam int GROUP_STRIDE = 12;

    function automatic int irq_lo(input int g);
        case (g)
            0:       return 0;
            1:       return 28;
            default: return 46;
        endcase
    endfunction

    function automatic int irq_hi(input int g, input int npins);
        case (g)
            0:       return 27;
            1:       return 45;
            default: return npins - 1;
        endcase
    endfunction

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int N           = 54,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [N-1:0]                 pin_i,
    input  logic [NUM_KIND-1:0][N-1:0]   arm_i,
    output logic [N-1:0]                 evt_o
);

    typedef struct packed {
        logic [N-1:0] prev;   // previous synchronised sample
        logic [N-1:0] raw;    // previous raw sample
    } det_state_t;

    det_state_t st_d, st_q;
    logic [N-1:0] smp;
    logic [NUM_KIND-1:0][N-1:0] hit;

    gpev_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (smp)
    );

    always_comb begin
        st_d.prev = smp;
        st_d.raw  = pin_i;

        hit[K_SRISE] =  smp   & ~st_q.prev;
        hit[K_SFALL] = ~smp   &  st_q.prev;
        hit[K_HIGH]  =  smp;
        hit[K_LOW]   = ~smp;
        hit[K_ARISE] =  pin_i & ~st_q.raw;
        hit[K_AFALL] = ~pin_i &  st_q.raw;

        evt_o = '0;
        for (int k = 0; k < NUM_KIND; k++) begin
            evt_o = evt_o | (hit[k] & arm_i[k]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/gpev_irq_or.sv
module gpev_irq_or #(
    parameter int W = 1
) (
    input  logic [W-1:0] flags_i,
    output logic         irq_o
);

    assign irq_o = |flags_i;

endmodule

// File: rtl/gpev_top.sv
module gpev_top
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BUS_W-1:0]    bus_wdata_i,
    output logic [BUS_W-1:0]    bus_rdata_o,
    output logic [NUM_IRQ-1:0]  irq_o
);

    localparam int NUM_BANKS  = (NUM_PINS + BUS_W - 1) / BUS_W;
    localparam int PAD_W      = NUM_BANKS * BUS_W;
    localparam int NUM_GROUPS = NUM_KIND + 1;   // group 0 is the pending word set
    localparam logic [PAD_W-1:0] PIN_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_PINS);

    typedef struct packed {
        logic [NUM_KIND-1:0][PAD_W-1:0] arm;
        logic [PAD_W-1:0]               pend;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [NUM_GROUPS-1:0][NUM_BANKS-1:0] addr_hit;
    logic [NUM_KIND-1:0][NUM_PINS-1:0]    det_arm;
    logic [NUM_PINS-1:0]                  evt;
    logic [PAD_W-1:0]                     clr;
    logic [PAD_W-1:0]                     status_q;

    // Address decode: one compare per register word.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                addr_hit[g][b] = (bus_addr_i == ADDR_W'(PEND_BASE + GROUP_STRIDE * g + 4 * b));
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_KIND; k++) begin
            det_arm[k] = st_q.arm[k][NUM_PINS-1:0];
        end
    end

    gpev_detect #(.N(NUM_PINS), .SYNC_STAGES(2)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .arm_i  (det_arm),
        .evt_o  (evt)
    );

    // Next-state: arm writes, write-one-to-clear, set over clear.
    always_comb begin
        st_d = st_q;
        clr  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_we_i && addr_hit[0][b]) begin
                clr[b*BUS_W +: BUS_W] = bus_wdata_i;
            end
        end
        for (int k = 0; k < NUM_KIND; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_we_i && addr_hit[k+1][b]) begin
                    st_d.arm[k][b*BUS_W +: BUS_W] = bus_wdata_i;
                end
            end
            st_d.arm[k] = st_d.arm[k] & PIN_MASK;
        end
        st_d.pend = ((st_q.pend & ~clr) | PAD_W'(evt)) & PIN_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Read path.
    always_comb begin
        bus_rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_hit[0][b]) bus_rdata_o = st_q.pend[b*BUS_W +: BUS_W];
        end
        for (int k = 0; k < NUM_KIND; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr_hit[k+1][b]) bus_rdata_o = st_q.arm[k][b*BUS_W +: BUS_W];
            end
        end
    end

    assign status_q = st_q.pend;

    // Interrupt folding over fixed pin spans.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        localparam int LO = irq_lo(g);
        localparam int HI = irq_hi(g, NUM_PINS);
        gpev_irq_or #(.W(HI - LO + 1)) u_or (
            .flags_i (st_q.pend[HI:LO]),
            .irq_o   (irq_o[g])
        );
    end

endmodule

// File: rtl/gpev_chk.sv
module gpev_chk
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int PAD_W    = 64
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                bus_we_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [BUS_W-1:0]    bus_wdata_i,
    input logic [BUS_W-1:0]    bus_rdata_o,
    input logic [NUM_IRQ-1:0]  irq_o,
    input logic [PAD_W-1:0]    status_q,
    input logic [NUM_PINS-1:0] evt
);

    localparam int NUM_BANKS = PAD_W / BUS_W;
    localparam int TOP_USED  = NUM_PINS - (NUM_BANKS - 1) * BUS_W;

    logic [PAD_W-1:0] clr_m;

    always_comb begin
        clr_m = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_we_i && bus_addr_i == ADDR_W'(PEND_BASE + 4 * b)) begin
                clr_m[b*BUS_W +: BUS_W] = bus_wdata_i;
            end
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(status_q) & ~status_q & ~$past(clr_m)) == '0)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q & PAD_W'($past(evt))) == PAD_W'($past(evt)))); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o != '0) |-> (status_q != '0)); // R10

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o & ~$past(irq_o)) != '0) |-> (status_q != $past(status_q))); // R10

    if (TOP_USED < BUS_W) begin : g_pad
        for (genvar g = 0; g < NUM_KIND + 1; g++) begin : g_grp
            AST_PAD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (bus_addr_i == ADDR_W'(PEND_BASE + GROUP_STRIDE * g + 4 * (NUM_BANKS - 1)))
                |-> (bus_rdata_o[BUS_W-1:TOP_USED] == '0)); // R2
        end
    end

endmodule

bind gpev_top gpev_chk #(
    .NUM_PINS (NUM_PINS),
    .BUS_W    (BUS_W),
    .ADDR_W   (ADDR_W),
    .PAD_W    (PAD_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .status_q    (status_q),
    .evt         (evt)
);

// File: tb/test_gpev_top.sv
module test_gpev_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [2:0]    irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpev_top i_gpev_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd_pend(output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(8'h40, lo);
        rd(8'h44, hi);
        v = {10'b0, hi[21:0], lo};
    endtask

    function automatic logic [2:0] irq_of(input logic [63:0] s);
        return {|s[53:46], |s[45:28], |s[27:0]};
    endfunction

    task automatic disarm_all();
        for (int k = 0; k < 6; k++) begin
            wr(8'(8'h4C + 12 * k), 32'h0);
            wr(8'(8'h50 + 12 * k), 32'h0);
        end
    endtask

    task automatic clear_pend();
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] p;
        logic [63:0] arm [6];
        logic [63:0] oldp, newp, expp;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every word and the interrupt lines
        for (int g = 0; g < 7; g++) begin
            for (int b = 0; b < 2; b++) begin
                rd(8'(8'h40 + 12 * g + 4 * b), r);
                chk("R1 reset word", 64'(r), 64'h0);
            end
        end
        chk("R1 reset irq", 64'(irq), 64'h0);

        // R2: arm read-back and padding of the upper word
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, r);
        chk("R2 upper word pad", 64'(r), 64'h003F_FFFF);
        wr(8'h58, 32'hA5A5_5A5A);
        rd(8'h58, r);
        chk("R2 arm readback", 64'(r), 64'hA5A5_5A5A);
        rd(8'h8C, r);
        chk("R2 untouched arm", 64'(r), 64'h0);
        disarm_all();

        // R11: pins toggle with nothing armed
        for (int i = 0; i < 6; i++) begin
            pins = {$urandom, $urandom};
            repeat (4) @(negedge clk);
        end
        rd_pend(p);
        chk("R11 unarmed pend", p, 64'h0);
        chk("R11 unarmed irq", 64'(irq), 64'h0);
        pins = '0;
        repeat (4) @(negedge clk);

        // R3: sync rising latency on pin 5
        wr(8'h4C, 32'h1 << 5);
        pins[5] = 1'b1;
        repeat (2) @(negedge clk);
        rd_pend(p);
        chk("R3 not yet after two edges", p, 64'h0);
        @(negedge clk);
        rd_pend(p);
        chk("R3 set after third edge", p, 64'h1 << 5);
        chk("R10 irq for pin 5", 64'(irq), 64'b001);

        // R9: disarming keeps the pending bit
        wr(8'h4C, 32'h0);
        repeat (2) @(negedge clk);
        rd_pend(p);
        chk("R9 pend kept after disarm", p, 64'h1 << 5);

        // R7: write zero keeps, write one clears
        wr(8'h40, 32'h0);
        rd_pend(p);
        chk("R7 write zero no effect", p, 64'h1 << 5);
        wr(8'h40, 32'h1 << 5);
        rd_pend(p);
        chk("R7 write one clears", p, 64'h0);
        chk("R7 irq drops", 64'(irq), 64'h0);
        pins[5] = 1'b0;
        repeat (4) @(negedge clk);

        // R6: fast rising on pin 40 (upper word bit 8)
        wr(8'h80, 32'h1 << 8);
        pins[40] = 1'b1;
        @(negedge clk);
        rd_pend(p);
        chk("R6 fast rise after one edge", p, 64'h1 << 40);
        chk("R10 irq for pin 40", 64'(irq), 64'b010);
        wr(8'h80, 32'h0);
        // R6: fast falling on pin 40
        clear_pend();
        wr(8'h8C, 32'h1 << 8);
        pins[40] = 1'b0;
        @(negedge clk);
        rd_pend(p);
        chk("R6 fast fall after one edge", p, 64'h1 << 40);
        wr(8'h8C, 32'h0);
        clear_pend();

        // R8: event and clear in the same cycle on pin 3
        wr(8'h7C, 32'h1 << 3);
        pins[3] = 1'b1;
        wr(8'h40, 32'h1 << 3);
        rd_pend(p);
        chk("R8 set beats clear", p, 64'h1 << 3);
        wr(8'h7C, 32'h0);
        pins[3] = 1'b0;
        @(negedge clk);
        clear_pend();

        // R4: both sync edges on pin 30
        wr(8'h4C, 32'h1 << 30);
        wr(8'h58, 32'h1 << 30);
        pins[30] = 1'b1;
        repeat (3) @(negedge clk);
        rd_pend(p);
        chk("R4 both-edge rise", p, 64'h1 << 30);
        chk("R10 irq for pin 30", 64'(irq), 64'b010);
        wr(8'h40, 32'h1 << 30);
        rd_pend(p);
        chk("R4 cleared between edges", p, 64'h0);
        pins[30] = 1'b0;
        repeat (2) @(negedge clk);
        rd_pend(p);
        chk("R4 fall not yet after two edges", p, 64'h0);
        @(negedge clk);
        rd_pend(p);
        chk("R4 both-edge fall", p, 64'h1 << 30);
        disarm_all();
        clear_pend();

        // R5: high level on pin 50 (upper word bit 18) overrides clear
        wr(8'h68, 32'h1 << 18);
        pins[50] = 1'b1;
        repeat (4) @(negedge clk);
        rd_pend(p);
        chk("R5 level sets", p, 64'h1 << 50);
        chk("R10 irq for pin 50", 64'(irq), 64'b100);
        wr(8'h44, 32'h1 << 18);
        rd_pend(p);
        chk("R5 clear overridden by level", p, 64'h1 << 50);
        pins[50] = 1'b0;
        wr(8'h68, 32'h0);
        repeat (3) @(negedge clk);
        rd_pend(p);
        chk("R9 level pend kept", p, 64'h1 << 50);
        // R5: low level on pin 12
        clear_pend();
        wr(8'h70, 32'h1 << 12);
        repeat (2) @(negedge clk);
        wr(8'h40, 32'h1 << 12);
        rd_pend(p);
        chk("R5 low level holds", p, 64'h1 << 12);
        wr(8'h70, 32'h0);
        clear_pend();
        rd_pend(p);
        chk("R5 low level cleared once disarmed", p, 64'h0);

        // R10: span boundaries with fast rising armed everywhere
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        foreach (arm[i]) arm[i] = '0;
        for (int i = 0; i < 4; i++) begin
            int pn;
            logic [2:0] ei;
            case (i)
                0: begin pn = 27; ei = 3'b001; end
                1: begin pn = 28; ei = 3'b010; end
                2: begin pn = 45; ei = 3'b010; end
                default: begin pn = 46; ei = 3'b100; end
            endcase
            pins[pn] = 1'b1;
            @(negedge clk);
            chk($sformatf("R10 span edge pin %0d", pn), 64'(irq), 64'(ei));
            pins[pn] = 1'b0;
            clear_pend();
            chk("R10 irq low after clear", 64'(irq), 64'h0);
        end
        disarm_all();
        clear_pend();

        // Random rounds: stable pattern, random arming, then a second pattern
        for (int rnd = 0; rnd < 24; rnd++) begin
            oldp = {10'b0, 22'($urandom), $urandom};
            newp = {10'b0, 22'($urandom), $urandom};
            disarm_all();
            pins = oldp[NP-1:0];
            repeat (5) @(negedge clk);
            clear_pend();
            for (int k = 0; k < 6; k++) begin
                arm[k] = {10'b0, 22'($urandom), $urandom} & {$urandom, $urandom};
                wr(8'(8'h4C + 12 * k), arm[k][31:0]);
                wr(8'(8'h50 + 12 * k), arm[k][63:32]);
            end
            pins = newp[NP-1:0];
            repeat (5) @(negedge clk);
            expp = (arm[2] & (oldp | newp))
                 | (arm[3] & ~(oldp & newp))
                 | ((arm[0] | arm[4]) & ~oldp & newp)
                 | ((arm[1] | arm[5]) & oldp & ~newp);
            expp = expp & 64'h003F_FFFF_FFFF_FFFF;
            rd_pend(p);
            chk("R3 R4 R5 R6 random pend", p, expp);
            chk("R10 random irq", 64'(irq), 64'(irq_of(expp)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule